// File: doc/BRIEF.md
# Exponential-Timeout Watchdog Timer

This block is a byte-wide watchdog timer that the host drives through a register port. The port has an address, write data, a write strobe and combinational read data. Time is counted from an external clock-enable pulse, `tick_i`, that is high for one clock cycle every eighth of a second. The timeout is never loaded as a linear count. Software writes a 4-bit exponent code `n`, and the block waits 2^n ticks, which is 2^(n-3) seconds. This gives a range from 0.125 s (code 0) up to 4096 s (code 15) in power-of-two steps.

Software programs the code in the setup register and then writes a fixed start pattern to the control/status register. It writes the same pattern again before each timeout runs out, and each such write is a keepalive. If the count runs out, the block raises a one-cycle reset-request pulse and sets a sticky expiry flag. It then reloads and keeps watching. Once started, the block cannot be stopped by a register write.

Top module: `wdt_exp_top`

## Requirements
- R1: After reset the watchdog is stopped, `rst_req_o` is low, the setup register reads 0x9F (code 15) and the control/status register reads 0x00.
- R2: After a reload with code n in setup bits [3:0], the reset request fires on exactly the 2^n-th `tick_i` cycle counted while running. Code 15 gives 32768 ticks.
- R3: Only a write of exactly 0x81 to address 1 starts the watchdog. Other values written there never start it, and while stopped no reset request occurs. Control/status bit 7 reads 1 once the watchdog is running.
- R4: A write of 0x81 to address 1 while running reloads the count to the full timeout. If it lands in the same cycle as a tick, the reload wins and that tick is not counted.
- R5: On expiry `rst_req_o` is high for one clock cycle, starting the cycle after the final tick. Control/status bit 0 then reads 1 from the cycle after the pulse.
- R6: Writing address 1 with bit 0 set clears the expiry flag. A write of 0x01 clears it without starting or reloading the count.
- R7: A write to the setup register while running changes nothing in the current countdown. The new code is used from the next reload, whether that reload comes from expiry or from a keepalive.
- R8: After expiry the count reloads automatically from the current code, and the watchdog stays running.
- R9: When an expiry pulse and a flag-clearing write fall in the same cycle, the flag ends up set.
- R10: Address 0 reads back the full setup byte as written. Addresses 2 and 3 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Eighth-second clock enable, one cycle wide |
| addr_i | input | 2 | Register address: 0 setup, 1 control/status |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
A table of codes 0 to 6 and 8 is applied first. For each code the bench checks that nothing fires on tick 2^n−1 and that the request fires on tick 2^n. This catches an off-by-one in the reload value or in the expiry compare, and it separates the exponent mapping from any linear mapping.

Directed sequences then cover the following:
- keepalives spaced just short of the timeout;
- a keepalive landing on a tick cycle;
- a setup write made in the middle of a countdown, which must not act until the following reload;
- back-to-back expiries under a continuous tick;
- a flag-clearing write that collides with the expiry pulse;
- non-start values and unmapped addresses;
- the full 32768-tick default after reset.

// File: rtl/wdt_exp_pkg.sv
`timescale 1ns/1ps
package wdt_exp_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned CODE_W = 4;
  localparam int unsigned CNT_W = 2 ** CODE_W;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 'd0;
  localparam logic [ADDR_W-1:0] ADDR_CS  = 'd1;

  localparam logic [DATA_W-1:0] CFG_RST  = 8'h9F;
  localparam logic [DATA_W-1:0] KICK_VAL = 8'h81;

  localparam int unsigned CS_EN_BIT  = 7;
  localparam int unsigned CS_STS_BIT = 0;

  typedef struct packed {
    logic                wr_cfg;
    logic                wr_cs;
    logic                kick;
    logic                clr_sts;
    logic [DATA_W-1:0]   data;
  } wr_dec_t;
endpackage

// File: rtl/wdt_exp_decode.sv
`timescale 1ns/1ps
module wdt_exp_decode
  import wdt_exp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output wr_dec_t           dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.data    = wdata_i;
    dec_o.wr_cfg  = we_i && (addr_i == ADDR_CFG);
    dec_o.wr_cs   = we_i && (addr_i == ADDR_CS);
    dec_o.kick    = dec_o.wr_cs && (wdata_i == KICK_VAL);
    dec_o.clr_sts = dec_o.wr_cs && wdata_i[CS_STS_BIT];
  end
endmodule

// File: rtl/wdt_exp_regs.sv
`timescale 1ns/1ps
module wdt_exp_regs
  import wdt_exp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_dec_t           dec_i,
  input  logic              expire_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic              en_o,
  output logic              sts_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cfg_q;
  logic              en_q;
  logic              sts_q;
  logic [DATA_W-1:0] cs_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (dec_i.wr_cfg) cfg_q <= dec_i.data;
      if (dec_i.kick)   en_q  <= 1'b1;
      // expiry dominates a simultaneous clear
      if (expire_i)          sts_q <= 1'b1;
      else if (dec_i.clr_sts) sts_q <= 1'b0;
    end
  end

  always_comb begin
    cs_rd             = '0;
    cs_rd[CS_EN_BIT]  = en_q;
    cs_rd[CS_STS_BIT] = sts_q;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CFG: rdata_o = cfg_q;
      ADDR_CS:  rdata_o = cs_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/wdt_exp_count.sv
`timescale 1ns/1ps
module wdt_exp_count
  import wdt_exp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              kick_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             last;

  // 2^code ticks of 1/8 s
  always_comb begin
    reload = '0;
    for (int unsigned i = 0; i < CNT_W; i++) begin
      if (code_i == CODE_W'(i)) reload[i] = 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (kick_i) begin
        cnt_q <= reload;
      end else if (en_i && tick_i) begin
        if (last) begin
          cnt_q    <= reload;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_exp_top.sv
`timescale 1ns/1ps
module wdt_exp_top
  import wdt_exp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  wr_dec_t           dec;
  logic [DATA_W-1:0] cfg;
  logic              en;
  logic              sts;
  logic              expire;
  logic [CNT_W-1:0]  cnt;

  wdt_exp_decode i_decode (
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .dec_o   (dec)
  );

  wdt_exp_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (dec),
    .expire_i (expire),
    .addr_i   (addr_i),
    .cfg_o    (cfg),
    .en_o     (en),
    .sts_o    (sts),
    .rdata_o  (rdata_o)
  );

  wdt_exp_count i_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .kick_i   (dec.kick),
    .tick_i   (tick_i),
    .code_i   (cfg[CODE_W-1:0]),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  assign rst_req_o = expire;
endmodule

// File: rtl/wdt_exp_chk.sv
`timescale 1ns/1ps
module wdt_exp_chk
  import wdt_exp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              rst_req_o,
  input logic              en,
  input logic              sts,
  input logic [DATA_W-1:0] cfg,
  input logic [CNT_W-1:0]  cnt
);
  // R2
  req_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(tick_i));
  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= (CNT_W'(1) << (CNT_W-1)));
  // R3
  req_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> en);
  // R4
  kick_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CS && wdata_i == KICK_VAL) |=> !rst_req_o);
  // R5
  req_sets_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> sts);
  // R10
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != ADDR_CFG && addr_i != ADDR_CS) |=> ($stable(cfg) && $stable(en)));
endmodule

bind wdt_exp_top wdt_exp_chk i_wdt_exp_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .rst_req_o (rst_req_o),
  .en        (en),
  .sts       (sts),
  .cfg       (cfg),
  .cnt       (cnt)
);

// File: tb/test_wdt_exp_top.sv
`timescale 1ns/1ps
module test_wdt_exp_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  int req_cnt = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wdt_exp_top i_wdt_exp_top (
    .clk_i, .rst_ni, .tick_i, .addr_i, .wdata_i, .we_i, .rdata_o, .rst_req_o
  );

  always @(posedge clk_i) if (rst_ni && rst_req_o) req_cnt <= req_cnt + 1;

  // {code[19:16], ticks[15:0]}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'd0, 16'd1}, {4'd1, 16'd2}, {4'd2, 16'd4}, {4'd3, 16'd8},
    {4'd4, 16'd16}, {4'd5, 16'd32}, {4'd6, 16'd64}, {4'd8, 16'd256}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base;
    @(negedge clk_i);
    do_reset();

    // R1 reset state
    check("R1 req", rst_req_o, 0);
    rd(0, d); check("R1 cfg", d, 8'h9F);
    rd(1, d); check("R1 cs", d, 8'h00);

    // R3 non-start values; R10 unmapped writes
    wr(0, 8'h90);
    wr(1, 8'h80);
    wr(1, 8'h7E);
    wr(2, 8'h81);
    wr(3, 8'h05);
    base = req_cnt;
    ticks(3); idle(1);
    check("R3 no req while stopped", req_cnt - base, 0);
    rd(1, d); check("R3 cs stopped", d, 8'h00);
    rd(0, d); check("R10 cfg untouched", d, 8'h90);
    rd(2, d); check("R10 addr2 reads 0", d, 8'h00);
    rd(3, d); check("R10 addr3 reads 0", d, 8'h00);

    // R2/R5/R6 vector table
    for (int v = 0; v < NV; v++) begin
      wr(0, {4'h9, VEC[v][19:16]});
      rd(0, d); check("R10 cfg readback", d, {4'h9, VEC[v][19:16]});
      wr(1, 8'h01);
      wr(1, 8'h81);
      rd(1, d); check("R3 running cs", d, 8'h80);
      base = req_cnt;
      ticks(int'(VEC[v][15:0]) - 1);
      idle(1);
      check("R2 no early req", req_cnt - base, 0);
      ticks(1);
      check("R5 req high", rst_req_o, 1);
      idle(1);
      check("R5 req one cycle", rst_req_o, 0);
      check("R2 req count", req_cnt - base, 1);
      rd(1, d); check("R5 sts set", d, 8'h81);
      wr(1, 8'h01);
      rd(1, d); check("R6 sts cleared", d, 8'h80);
    end

    // R6: a 0x01 write does not reload the count
    wr(0, 8'h92);
    wr(1, 8'h81);
    base = req_cnt;
    ticks(2);
    wr(1, 8'h01);
    ticks(2); idle(1);
    check("R6 clear no reload", req_cnt - base, 1);

    // R4 keepalive
    wr(0, 8'h92);
    wr(1, 8'h81);
    base = req_cnt;
    ticks(3); wr(1, 8'h81);
    ticks(3); wr(1, 8'h81);
    ticks(3); idle(1);
    check("R4 keepalive holds off", req_cnt - base, 0);
    ticks(1); idle(1);
    check("R4 expiry after last keepalive", req_cnt - base, 1);

    // R4 keepalive on a tick cycle wins
    wr(0, 8'h90);
    wr(1, 8'h81);
    base = req_cnt;
    tick_i = 1'b1;
    wr(1, 8'h81);
    tick_i = 1'b0;
    idle(1);
    check("R4 kick beats tick", req_cnt - base, 0);
    ticks(1); idle(1);
    check("R4 next tick expires", req_cnt - base, 1);

    // R7 setup write mid-run; R8 auto reload
    wr(0, 8'h92);
    wr(1, 8'h81);
    base = req_cnt;
    ticks(1);
    wr(0, 8'h90);
    ticks(2); idle(1);
    check("R7 old code still counting", req_cnt - base, 0);
    ticks(1); idle(1);
    check("R7 expiry at old timeout", req_cnt - base, 1);
    ticks(1); idle(1);
    check("R8 reload uses new code", req_cnt - base, 2);
    rd(1, d); check("R8 still running", d[7], 1);

    // R8 continuous ticks, code 1
    wr(0, 8'h91);
    wr(1, 8'h81);
    base = req_cnt;
    ticks(6); idle(1);
    check("R8 repeated expiry", req_cnt - base, 3);

    // R9 clear collides with expiry pulse
    wr(0, 8'h90);
    wr(1, 8'h01);
    wr(1, 8'h81);
    ticks(1);
    wr(1, 8'h01);
    rd(1, d); check("R9 expiry beats clear", d, 8'h81);
    wr(1, 8'h01);
    rd(1, d); check("R6 clear after collision", d, 8'h80);

    // R1/R2 default code 15 after reset
    do_reset();
    rd(0, d); check("R1 cfg after re-reset", d, 8'h9F);
    wr(1, 8'h81);
    base = req_cnt;
    ticks(32767); idle(1);
    check("R2 code15 no early req", req_cnt - base, 0);
    ticks(1); idle(1);
    check("R2 code15 expiry", req_cnt - base, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule